// File: doc/BRIEF.md
# Word-Write Command Packet Serializer

This block turns a run of 32-bit words, bound for consecutive word addresses that begin at a start offset, into byte-stream command packets for a bridge link. A start pulse carries the first word address and the number of words. The words then arrive one at a time on a ready/valid input. Packet bytes leave on a ready/valid byte output, and a marker flags the final byte of every packet.

Each word is framed as a 7-byte record. The data word comes first, low byte first. The 24-bit target word address follows, high byte first. A packet is one opcode byte followed by up to a fixed number of records. A longer run is cut into several packets, and the word address moves forward between them. After every packet the link returns a response. A failure response ends the run at once. Completion is reported by a one-cycle done pulse, with an error flag beside it.

Top module: `wordpkt_serializer`

## Requirements
- R1: The first byte of every packet is the opcode value 0x01.
- R2: A packet carries at most MAX_WORDS records (default 8). A run longer than that is split into full packets followed by one packet holding the remainder, and every word of the run is sent exactly once, in input order.
- R3: Record bytes 0 to 3 are the data word, least significant byte first (byte 0 = bits 7:0, byte 3 = bits 31:24).
- R4: Record bytes 4 to 6 are the 24-bit word address, most significant byte first (byte 4 = bits 23:16, byte 6 = bits 7:0). The address of the i-th record in a packet (i counted from 0) is the packet base plus i, modulo 2^24.
- R5: A packet holding n records is exactly 1 + 7n bytes long. bo_last is high on its final byte and on no other byte.
- R6: After a packet is acknowledged without error, the base of the next packet is the previous base plus the number of records just sent, modulo 2^24.
- R7: While bo_valid is high and bo_ready is low, bo_valid, bo_data and bo_last keep their values into the next cycle.
- R8: A response with resp_err high, taken after any packet, ends the run. No further byte is sent and no further word is taken. done and err are then high together in the next cycle.
- R9: A start with a word count of zero sends no byte and takes no word. done is high with err low in the cycle after the start.
- R10: A word is taken only while wd_ready is high, and wd_ready is high only while no byte is offered. A start pulse seen while busy is high is ignored.
- R11: After the response to the final packet is taken without error, done is high for exactly one cycle in the next cycle, with err low and busy low.
- R12: While reset is high and right after it, busy, wd_ready, bo_valid, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when busy is low) |
| start_addr | input | 24 | First word address of the run |
| word_count | input | CNT_W | Number of words in the run |
| busy | output | 1 | A run is in progress |
| wd_valid | input | 1 | Input word valid |
| wd_data | input | 32 | Input word |
| wd_ready | output | 1 | Block takes a word this cycle if wd_valid is high |
| bo_valid | output | 1 | Output byte valid |
| bo_data | output | 8 | Output byte |
| bo_last | output | 1 | Final byte of the current packet |
| bo_ready | input | 1 | Downstream takes the byte |
| resp_valid | input | 1 | Per-packet response valid |
| resp_err | input | 1 | Response reports failure |
| done | output | 1 | One-cycle run completion pulse |
| err | output | 1 | Run ended on a failure response (valid with done) |

## Verification
Several behaviours are checked on every cycle. These are the output hold under back-pressure, the opcode at the head of each packet, the 1 + 7n packet length with its record cap, the exclusion between taking words and offering bytes, the zero-count done, and the silence after a failure. The exact byte order of the data and address fields, the address advance across packet boundaries and through the 24-bit wrap, and the order of words across packets can only be shown by the bench. It compares every byte against a stream built from the requirements, over directed and random runs with random stalls and failures placed on chosen packets.

// File: rtl/wps_pkg.sv
package wps_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 24;
    localparam int unsigned REC_BYTES = 7;
    localparam int unsigned DATA_BYTES = DATA_W / 8;
    localparam int unsigned ADDR_BYTES = ADDR_W / 8;
    localparam logic [7:0]  OPCODE    = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_FETCH,
        ST_REC,
        ST_RESP
    } wps_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [ADDR_W-1:0] addr;
    } wps_rec_t;

    function automatic logic is_final_byte(input logic [2:0] idx);
        return idx == 3'(REC_BYTES - 1);
    endfunction

endpackage

// File: rtl/wps_run_tracker.sv
module wps_run_tracker
    import wps_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int MAX_WORDS = 8,
    parameter int CHUNK_W   = $clog2(MAX_WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ADDR_W-1:0]  load_addr,
    input  logic [CNT_W-1:0]   load_cnt,
    input  logic               advance,
    output logic [ADDR_W-1:0]  base,
    output logic [CHUNK_W-1:0] chunk,
    output logic               final_chunk
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_WORDS);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            base      <= '0;
            remaining <= '0;
        end else if (load) begin
            base      <= load_addr;
            remaining <= load_cnt;
        end else if (advance) begin
            base      <= base + ADDR_W'(chunk);
            remaining <= remaining - CNT_W'(chunk);
        end
    end

    always_comb begin
        if (remaining > CAP) begin
            chunk = CHUNK_W'(MAX_WORDS);
        end else begin
            chunk = CHUNK_W'(remaining);
        end
        final_chunk = (remaining <= CAP);
    end

endmodule

// File: rtl/wps_record_fmt.sv
module wps_record_fmt
    import wps_pkg::*;
(
    input  wps_rec_t   rec,
    input  logic [2:0] idx,
    output logic [7:0] byte_out
);

    logic [7:0] lane [8];

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_data
        assign lane[g] = rec.word[8*g +: 8];
    end

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
        assign lane[DATA_BYTES + g] = rec.addr[8*(ADDR_BYTES-1-g) +: 8];
    end

    assign lane[7] = 8'h00;

    assign byte_out = lane[idx];

endmodule

// File: rtl/wordpkt_serializer.sv
module wordpkt_serializer
    import wps_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int MAX_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [23:0]       start_addr,
    input  logic [CNT_W-1:0]  word_count,
    output logic              busy,
    input  logic              wd_valid,
    input  logic [31:0]       wd_data,
    output logic              wd_ready,
    output logic              bo_valid,
    output logic [7:0]        bo_data,
    output logic              bo_last,
    input  logic              bo_ready,
    input  logic              resp_valid,
    input  logic              resp_err,
    output logic              done,
    output logic              err
);

    localparam int CHUNK_W = $clog2(MAX_WORDS + 1);

    wps_state_e          state;
    logic [DATA_W-1:0]   word_q;
    logic [CHUNK_W-1:0]  slot;
    logic [CHUNK_W-1:0]  slot_nxt;
    logic [2:0]          bidx;
    logic                done_q;
    logic                err_q;

    logic                load;
    logic                advance;
    logic [ADDR_W-1:0]   base;
    logic [CHUNK_W-1:0]  chunk;
    logic                final_chunk;
    logic                last_slot;
    wps_rec_t            rec;
    logic [7:0]          rec_byte;

    assign load      = (state == ST_IDLE) && start && (word_count != '0);
    assign advance   = (state == ST_RESP) && resp_valid && !resp_err;
    assign slot_nxt  = slot + CHUNK_W'(1);
    assign last_slot = (slot_nxt == chunk);

    wps_run_tracker #(
        .CNT_W     (CNT_W),
        .MAX_WORDS (MAX_WORDS),
        .CHUNK_W   (CHUNK_W)
    ) u_track (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .load_addr   (start_addr),
        .load_cnt    (word_count),
        .advance     (advance),
        .base        (base),
        .chunk       (chunk),
        .final_chunk (final_chunk)
    );

    assign rec.word = word_q;
    assign rec.addr = base + ADDR_W'(slot);

    wps_record_fmt u_fmt (
        .rec      (rec),
        .idx      (bidx),
        .byte_out (rec_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            word_q <= '0;
            slot   <= '0;
            bidx   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (word_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_OPC;
                        end
                    end
                end
                ST_OPC: begin
                    if (bo_ready) begin
                        slot  <= '0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (wd_valid) begin
                        word_q <= wd_data;
                        bidx   <= '0;
                        state  <= ST_REC;
                    end
                end
                ST_REC: begin
                    if (bo_ready) begin
                        if (is_final_byte(bidx)) begin
                            if (last_slot) begin
                                state <= ST_RESP;
                            end else begin
                                slot  <= slot_nxt;
                                state <= ST_FETCH;
                            end
                        end else begin
                            bidx <= bidx + 3'd1;
                        end
                    end
                end
                ST_RESP: begin
                    if (resp_valid) begin
                        if (resp_err) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            state  <= ST_IDLE;
                        end else if (final_chunk) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_OPC;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        wd_ready = (state == ST_FETCH);
        bo_valid = (state == ST_OPC) || (state == ST_REC);
        bo_data  = (state == ST_OPC) ? OPCODE : rec_byte;
        bo_last  = (state == ST_REC) && is_final_byte(bidx) && last_slot;
        done     = done_q;
        err      = err_q;
    end

endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
    parameter int CNT_W     = 16,
    parameter int MAX_WORDS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] word_count,
    input logic             busy,
    input logic             wd_ready,
    input logic             bo_valid,
    input logic [7:0]       bo_data,
    input logic             bo_last,
    input logic             bo_ready,
    input logic             done,
    input logic             err
);

    logic [15:0] pkt_bytes;

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_bytes <= '0;
        end else if (bo_valid && bo_ready) begin
            pkt_bytes <= bo_last ? 16'd0 : pkt_bytes + 16'd1;
        end
    end

    // R7: offered byte held under back-pressure
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (bo_valid && !bo_ready) |=> (bo_valid && $stable(bo_data) && $stable(bo_last)));

    // R1: packet head is the opcode
    p_opcode_r1: assert property (@(posedge clk) disable iff (rst)
        (bo_valid && pkt_bytes == 16'd0) |-> (bo_data == 8'h01));

    // R5 and R2: length 1 + 7n with n between 1 and the cap
    p_pktlen_r5: assert property (@(posedge clk) disable iff (rst)
        (bo_valid && bo_last) |-> (pkt_bytes >= 16'd7 && (pkt_bytes % 16'd7) == 16'd0
                                   && (pkt_bytes / 16'd7) <= 16'(MAX_WORDS)));

    // R9: zero count finishes on the next cycle without error
    p_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && word_count == '0) |=> (done && !err && !busy));

    // R8: error only comes with done
    p_errdone_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R8: nothing offered once a failed run ends
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (!bo_valid && !wd_ready));

    // R10: words are taken only while no byte is offered
    p_fetch_r10: assert property (@(posedge clk) disable iff (rst)
        wd_ready |-> (!bo_valid && busy));

    // R11: done leaves the block idle
    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind wordpkt_serializer wps_checker #(
    .CNT_W     (CNT_W),
    .MAX_WORDS (MAX_WORDS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .word_count (word_count),
    .busy       (busy),
    .wd_ready   (wd_ready),
    .bo_valid   (bo_valid),
    .bo_data    (bo_data),
    .bo_last    (bo_last),
    .bo_ready   (bo_ready),
    .done       (done),
    .err        (err)
);

// File: tb/sim_wordpkt_serializer.sv
module sim_wordpkt_serializer;

    localparam int CW   = 16;
    localparam int MAXW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [23:0]   start_addr = '0;
    logic [CW-1:0] word_count = '0;
    logic          busy;
    logic          wd_valid = 1'b0;
    logic [31:0]   wd_data = '0;
    logic          wd_ready;
    logic          bo_valid;
    logic [7:0]    bo_data;
    logic          bo_last;
    logic          bo_ready = 1'b0;
    logic          resp_valid = 1'b0;
    logic          resp_err = 1'b0;
    logic          done;
    logic          err;

    always #2 clk = ~clk;

    wordpkt_serializer #(.CNT_W(CW), .MAX_WORDS(MAXW)) u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .word_count(word_count), .busy(busy), .wd_valid(wd_valid),
        .wd_data(wd_data), .wd_ready(wd_ready), .bo_valid(bo_valid),
        .bo_data(bo_data), .bo_last(bo_last), .bo_ready(bo_ready),
        .resp_valid(resp_valid), .resp_err(resp_err), .done(done), .err(err)
    );

    int checks = 0;
    int failures = 0;

    logic [8:0]  exp_b   [0:2047];
    string       exp_tag [0:2047];
    int          exp_n;
    int          exp_words;
    logic [31:0] words   [0:255];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] b, input bit last, input string tag);
        exp_b[exp_n]   = {last, b};
        exp_tag[exp_n] = tag;
        exp_n++;
    endtask

    // Build the expected byte stream from the requirements.
    task automatic build(input logic [23:0] addr, input int cnt, input int err_pkt);
        int          rem = cnt;
        int          w = 0;
        int          p = 0;
        logic [23:0] pbase = addr;
        exp_n = 0;
        exp_words = 0;
        while (rem > 0) begin
            int n = (rem > MAXW) ? MAXW : rem;
            push(8'h01, 1'b0, "R1");
            for (int i = 0; i < n; i++) begin
                logic [23:0] a = pbase + 24'(i);
                for (int b = 0; b < 4; b++) push(words[w + i][8*b +: 8], 1'b0, "R3");
                push(a[23:16], 1'b0, (p == 0) ? "R4" : "R6");
                push(a[15:8],  1'b0, (p == 0) ? "R4" : "R6");
                push(a[7:0],   (i == n - 1), (p == 0) ? "R4" : "R6");
            end
            w += n;
            exp_words += n;
            pbase += 24'(n);
            rem -= n;
            if (p == err_pkt) break;
            p++;
        end
    endtask

    task automatic run(input logic [23:0] addr, input int cnt, input int err_pkt,
                       input bit poke);
        int  cyc = 0;
        int  got = 0;
        int  taken = 0;
        int  pkt = 0;
        int  resp_cyc = -1;
        int  fail0 = failures;
        bit  pend = 0;
        bit  holding = 0;
        bit  finished = 0;
        bit  exp_err;
        logic [8:0] held = '0;

        for (int i = 0; i < 256; i++) words[i] = $urandom;
        build(addr, cnt, err_pkt);
        exp_err = (err_pkt >= 0) && (err_pkt * MAXW < cnt);

        @(negedge clk);
        start = 1'b1; start_addr = addr; word_count = CW'(cnt);
        while (!finished && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (poke && cyc == 20) begin
                // R10: start pulse while busy must be ignored
                start = 1'b1; start_addr = 24'h123456; word_count = CW'(3);
            end
            if (holding) begin
                check(bo_valid && {bo_last, bo_data} == held, "R7", "held byte",
                      {bo_valid, bo_last, bo_data}, {1'b1, held});
            end
            if (done) begin
                finished = 1;
                check(err == exp_err, exp_err ? "R8" : "R11", "err with done", err, exp_err);
                check(!bo_valid && !busy, "R8", "quiet at done", {bo_valid, busy}, 0);
                if (cnt == 0) check(cyc == 1, "R9", "zero-count done cycle", cyc, 1);
                else check(cyc == resp_cyc + 1, "R11", "done timing", cyc, resp_cyc + 1);
                bo_ready = 1'b0; wd_valid = 1'b0; resp_valid = 1'b0; resp_err = 1'b0;
            end else begin
                if (resp_valid) begin
                    resp_valid = 1'b0; resp_err = 1'b0;
                end else if (pend && ($urandom % 3 == 0)) begin
                    resp_valid = 1'b1;
                    resp_err   = (pkt == err_pkt);
                    pkt++;
                    pend = 0;
                    resp_cyc = cyc;
                end
                wd_valid = ($urandom % 4 != 0) && (taken < cnt);
                wd_data  = words[taken];
                if (wd_valid && wd_ready) taken++;
                bo_ready = ($urandom % 4 != 0);
                holding = bo_valid && !bo_ready;
                held = {bo_last, bo_data};
                if (bo_valid && bo_ready) begin
                    if (got < exp_n) begin
                        check({bo_last, bo_data} == exp_b[got],
                              bo_last != exp_b[got][8] ? "R5" : exp_tag[got],
                              $sformatf("byte %0d", got), {bo_last, bo_data}, exp_b[got]);
                    end else begin
                        check(1'b0, "R8", "byte beyond expected stream", got, exp_n);
                    end
                    got++;
                    if (bo_last) pend = 1;
                end
            end
        end
        check(finished, "R11", "run finished (watchdog)", cyc, 0);
        check(got == exp_n, "R5", "bytes sent in run", got, exp_n);
        check(taken == exp_words, "R2", "words taken in run", taken, exp_words);
        @(negedge clk);
        check(!done, "R11", "done is one cycle", done, 0);
        if (poke) check(failures == fail0, "R10", "run unchanged by start while busy",
                        failures - fail0, 0);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired R11 actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        // R12: reset state
        check(!busy && !wd_ready && !bo_valid && !done && !err, "R12", "outputs in reset",
              {busy, wd_ready, bo_valid, done, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !wd_ready && !bo_valid && !done && !err, "R12", "outputs after reset",
              {busy, wd_ready, bo_valid, done, err}, 0);

        run(24'h000010, 0, -1, 0);   // R9
        run(24'h000000, 1, -1, 0);   // single record
        run(24'h00ABCD, 8, -1, 0);   // exactly one full packet, R2
        run(24'h100000, 9, -1, 0);   // full plus remainder, R6
        run(24'hFFFFFC, 17, -1, 1);  // address wrap across packets, R10 poke
        run(24'h000200, 20, 0, 0);   // R8 failure on first packet
        run(24'h000300, 20, 1, 1);   // R8 failure on middle packet
        run(24'h000400, 16, 1, 0);   // R8 failure on final packet
        for (int k = 0; k < 12; k++) begin
            int c  = 1 + int'($urandom % 40);
            int ep = ($urandom % 3 == 0) ? int'($urandom % ((c + MAXW - 1) / MAXW)) : -1;
            run(24'($urandom), c, ep, (k % 4) == 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule